// File: doc/BRIEF.md
# Power Partition Gate Controller

This block switches a set of independently powered partitions on and off, reports which of them are powered, and controls the isolation clamps on each partition's outputs. Software drives it through a simple memory-mapped write/read bus. The analog power switch of each partition is outside the block. It appears as a level handshake: the block drives a switch target, and the switch answers with an acknowledge level once the rail has reached that state.

Power changes in only one way: a single toggle command that carries a start flag and a partition id. Only one partition may be in transition at a time. Clamps are released by a mask write. Clamps come back on by themselves when a partition is switched off. One pair of partitions has its clamp-release bits crossed over. The graphics partition also has a second release path through its own control word.

Top module: `pwr_partition_ctrl`

## Requirements
- R1: After reset, all switch targets are low, every clamp output is high, both error flags are low, and the status word reads zero.
- R2: A write to offset 0x030 with bit 8 set and an in-range id in bits 7:0 inverts that partition's switch target. The inversion is visible after the next clock edge, and no other target moves.
- R3: A read of offset 0x038 returns the power state in bit n for partition n, with the other bits zero. The data appears on rdata in the cycle after the one in which rd_en is sampled.
- R4: A toggle write with bit 8 clear has no effect on targets, clamps or error flags.
- R5: A partition's status bit takes the value of its target only once switch_ack equals the target. A command that is not yet acknowledged is not visible in the status word.
- R6: A write of a mask to offset 0x034 drops the clamp of each selected partition whose switch target is high. Mask bits for partitions whose target is low have no effect.
- R7: The release bits for partitions SWAP_A and SWAP_B (3 and 4 by default) are crossed. Mask bit 4 releases partition 3, and mask bit 3 releases partition 4.
- R8: A toggle with bit 8 set and an id of NUM_PART or above sets the sticky err_range flag and changes nothing else.
- R9: Writing zero to offset 0x2D4 releases the clamp of partition GFX_ID (1 by default) when its target is high. A nonzero value written there is ignored.
- R10: A toggle that arrives while any partition awaits its acknowledge is dropped and sets the sticky err_busy flag. This includes the very cycle in which that acknowledge completes the transition.
- R11: Accepting a toggle that turns a partition off raises its clamp at the same edge as its target falls. The clamp stays high while the target is low.
- R12: Reads of any offset other than 0x038 return zero, including the write-only command offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle after rd_en |
| switch_target | output | NUM_PART | Requested power level per partition |
| switch_ack | input | NUM_PART | Power level reached by each switch |
| clamp | output | NUM_PART | Isolation clamp per partition, high means clamped |
| err_range | output | 1 | Sticky flag: toggle for an id out of range |
| err_busy | output | 1 | Sticky flag: toggle dropped during a transition |

## Verification
The critical coincidence is an acknowledge that completes one partition's transition in the same cycle as a new toggle write for a different partition. The bench holds the switch under manual control for this case. At a single falling edge it raises the pending acknowledge and presents the second toggle. It then expects the status bit of the first partition to be set, the second partition's target to stay low, and err_busy to rise. A following toggle for the second partition must then be accepted. The same manual mode is used to read the status word between a command and its acknowledge.

// File: rtl/pgc_pkg.sv
// Shared types and helpers for the power partition gate controller.
package pgc_pkg;

    // Register targeted by a bus access.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TOGGLE,
        SEL_CLAMP,
        SEL_STATUS,
        SEL_GFX
    } reg_sel_e;

    // Mask bit that releases a given partition. The two crossed partitions
    // trade bits; every other partition uses its own id.
    function automatic int unsigned clamp_bit_for(input int unsigned part,
                                                  input int unsigned a,
                                                  input int unsigned b);
        if (part == a) return b;
        if (part == b) return a;
        return part;
    endfunction

endpackage

// File: rtl/pgc_bus_decode.sv
// Bus write decoder.
// Turns one write into the per-partition toggle and release strobes, and
// into the two error pulses.
// Assumes at most one write per cycle. Bit 8 is the start flag of a toggle.
// Bits 7:0 carry the partition id.
module pgc_bus_decode #(
    parameter int unsigned NUM_PART   = 7,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] OFS_TOGGLE = 12'h030,
    parameter logic [ADDR_W-1:0] OFS_CLAMP  = 12'h034,
    parameter logic [ADDR_W-1:0] OFS_GFX    = 12'h2D4,
    parameter int unsigned SWAP_A     = 3,
    parameter int unsigned SWAP_B     = 4,
    parameter int unsigned GFX_ID     = 1,
    parameter bit          GFX_ALT_EN = 1'b1
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    output logic [NUM_PART-1:0] toggle_sel,
    output logic [NUM_PART-1:0] release_sel,
    output logic                range_err,
    output logic                busy_err
);
    localparam int unsigned ID_W      = 8;
    localparam int unsigned START_BIT = 8;
    localparam logic [ID_W:0] PART_LIM = (ID_W+1)'(NUM_PART);

    pgc_pkg::reg_sel_e sel;
    logic [ID_W-1:0]   cmd_id;
    logic              toggle_cmd;
    logic              in_range;
    logic              toggle_fire;
    logic              clamp_wr;
    logic              gfx_hit;

    // Classify the written offset.
    always_comb begin
        sel = pgc_pkg::SEL_NONE;
        if (addr == OFS_TOGGLE)                   sel = pgc_pkg::SEL_TOGGLE;
        else if (addr == OFS_CLAMP)               sel = pgc_pkg::SEL_CLAMP;
        else if (GFX_ALT_EN && addr == OFS_GFX)   sel = pgc_pkg::SEL_GFX;
    end

    assign cmd_id      = wdata[ID_W-1:0];
    assign in_range    = {1'b0, cmd_id} < PART_LIM;
    assign toggle_cmd  = wr_en && (sel == pgc_pkg::SEL_TOGGLE) && wdata[START_BIT];
    assign range_err   = toggle_cmd && !in_range;
    assign busy_err    = toggle_cmd && in_range && busy;
    assign toggle_fire = toggle_cmd && in_range && !busy;
    assign clamp_wr    = wr_en && (sel == pgc_pkg::SEL_CLAMP);
    assign gfx_hit     = wr_en && (sel == pgc_pkg::SEL_GFX) && (wdata == '0);

    // One toggle strobe and one release strobe per partition.
    for (genvar i = 0; i < NUM_PART; i++) begin : g_part
        localparam int unsigned SRC = pgc_pkg::clamp_bit_for(i, SWAP_A, SWAP_B);
        assign toggle_sel[i] = toggle_fire && (cmd_id == ID_W'(i));
        if (GFX_ALT_EN && i == GFX_ID) begin : g_gfx
            assign release_sel[i] = (clamp_wr && wdata[SRC]) || gfx_hit;
        end else begin : g_plain
            assign release_sel[i] = clamp_wr && wdata[SRC];
        end
    end

endmodule

// File: rtl/pgc_partition.sv
// State of one power partition: switch target, acknowledged power state
// and isolation clamp.
// Assumes a toggle strobe only arrives while the partition is settled.
// A release has effect only while the target is on.
module pgc_partition (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_hit,
    input  logic release_hit,
    input  logic switch_ack,
    output logic target,
    output logic powered,
    output logic clamp,
    output logic pending
);
    assign pending = target != powered;

    // Target follows the toggle: invert the settled power state.
    always_ff @(posedge clk) begin
        if (!rst_n)          target <= 1'b0;
        else if (toggle_hit) target <= !powered;
    end

    // Power state takes the target once the switch acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n)                               powered <= 1'b0;
        else if (pending && switch_ack == target) powered <= target;
    end

    // Clamp rises on an accepted off request and drops on a release while on.
    always_ff @(posedge clk) begin
        if (!rst_n)                        clamp <= 1'b1;
        else if (toggle_hit && powered)    clamp <= 1'b1;
        else if (release_hit && target)    clamp <= 1'b0;
    end

endmodule

// File: rtl/pgc_readback.sv
// Registered read port.
// Returns the power status word for the status offset and zero for every
// other offset. Data is valid in the cycle after rd_en.
module pgc_readback #(
    parameter int unsigned NUM_PART = 7,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h038
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PART-1:0] status,
    output logic [DATA_W-1:0]   rdata
);
    // Capture the status word on a status read, otherwise return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= '0;
            if (rd_en && addr == OFS_STATUS) rdata[NUM_PART-1:0] <= status;
        end
    end

endmodule

// File: rtl/pwr_partition_ctrl.sv
// Power partition gate controller, top level.
// Decodes bus writes into toggle and clamp-release strobes, keeps one state
// slice per partition and holds the sticky error flags. Only one partition
// may be in transition at a time.
// Assumes NUM_PART <= 32 and DATA_W > 8.
module pwr_partition_ctrl #(
    parameter int unsigned NUM_PART   = 7,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter logic [ADDR_W-1:0] OFS_TOGGLE = 12'h030,
    parameter logic [ADDR_W-1:0] OFS_CLAMP  = 12'h034,
    parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h038,
    parameter logic [ADDR_W-1:0] OFS_GFX    = 12'h2D4,
    parameter int unsigned SWAP_A     = 3,
    parameter int unsigned SWAP_B     = 4,
    parameter int unsigned GFX_ID     = 1,
    parameter bit          GFX_ALT_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_PART-1:0] switch_target,
    input  logic [NUM_PART-1:0] switch_ack,
    output logic [NUM_PART-1:0] clamp,
    output logic                err_range,
    output logic                err_busy
);
    logic [NUM_PART-1:0] toggle_sel;
    logic [NUM_PART-1:0] release_sel;
    logic [NUM_PART-1:0] status_vec;
    logic [NUM_PART-1:0] pending_vec;
    logic                busy;
    logic                range_err;
    logic                busy_err;

    assign busy = |pending_vec;

    pgc_bus_decode #(
        .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_TOGGLE(OFS_TOGGLE), .OFS_CLAMP(OFS_CLAMP), .OFS_GFX(OFS_GFX),
        .SWAP_A(SWAP_A), .SWAP_B(SWAP_B), .GFX_ID(GFX_ID), .GFX_ALT_EN(GFX_ALT_EN)
    ) u_decode (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .busy(busy),
        .toggle_sel(toggle_sel), .release_sel(release_sel),
        .range_err(range_err), .busy_err(busy_err)
    );

    for (genvar i = 0; i < NUM_PART; i++) begin : g_slice
        pgc_partition u_part (
            .clk(clk), .rst_n(rst_n),
            .toggle_hit(toggle_sel[i]), .release_hit(release_sel[i]),
            .switch_ack(switch_ack[i]),
            .target(switch_target[i]), .powered(status_vec[i]),
            .clamp(clamp[i]), .pending(pending_vec[i])
        );
    end

    pgc_readback #(
        .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_STATUS(OFS_STATUS)
    ) u_readback (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .status(status_vec), .rdata(rdata)
    );

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_range <= 1'b0;
            err_busy  <= 1'b0;
        end else begin
            if (range_err) err_range <= 1'b1;
            if (busy_err)  err_busy  <= 1'b1;
        end
    end

endmodule

// File: rtl/pgc_checker.sv
// Property checker for pwr_partition_ctrl, attached with bind.
module pgc_checker #(
    parameter int unsigned NUM_PART = 7,
    parameter int unsigned ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFS_TOGGLE = 12'h030
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [8:0]          cmd_word,
    input logic [NUM_PART-1:0] switch_target,
    input logic [NUM_PART-1:0] switch_ack,
    input logic [NUM_PART-1:0] clamp,
    input logic [NUM_PART-1:0] status_q,
    input logic                err_range,
    input logic                err_busy
);
    localparam logic [8:0] LIM = 9'(NUM_PART);

    // No write, no target movement (R2).
    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(switch_target));

    // At most one partition moves per cycle (R10).
    assert_single_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(switch_target ^ $past(switch_target)) <= 1);

    // The busy error flag never clears on its own (R10).
    assert_busy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy |=> err_busy);

    // An out-of-range toggle raises the range flag (R8).
    assert_range_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_TOGGLE && cmd_word[8] && {1'b0, cmd_word[7:0]} >= LIM)
        |=> err_range);

    for (genvar i = 0; i < NUM_PART; i++) begin : g_bit
        // A partition whose target is off stays clamped (R11).
        assert_off_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !switch_target[i] |-> clamp[i]);

        // Status holds until the switch acknowledges the target (R5).
        assert_ack_gates_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (switch_ack[i] != switch_target[i]) |=> $stable(status_q[i]));
    end

endmodule

bind pwr_partition_ctrl pgc_checker #(
    .NUM_PART(NUM_PART), .ADDR_W(ADDR_W), .OFS_TOGGLE(OFS_TOGGLE)
) u_pgc_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .cmd_word(wdata[8:0]), .switch_target(switch_target),
    .switch_ack(switch_ack), .clamp(clamp), .status_q(status_vec),
    .err_range(err_range), .err_busy(err_busy)
);

// File: tb/tb_pwr_partition_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_partition_ctrl;
    localparam int NP  = 7;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] switch_target, switch_ack, clamp;
    logic          err_range, err_busy;

    logic [NP-1:0] auto_ack = '0;
    logic [NP-1:0] man_ack = '0;
    logic          sw_manual = 1'b0;
    bit            done = 1'b0;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [31:0]   exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    assign switch_ack = sw_manual ? man_ack : auto_ack;

    pwr_partition_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .switch_target(switch_target),
        .switch_ack(switch_ack), .clamp(clamp), .err_range(err_range),
        .err_busy(err_busy)
    );

    // Power switch model: follows the target after LAT falling edges.
    initial begin
        int cnt[NP];
        for (int i = 0; i < NP; i++) cnt[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) begin
                if (!rst_n) begin
                    auto_ack[i] = 1'b0; cnt[i] = 0;
                end else if (auto_ack[i] != switch_target[i]) begin
                    if (cnt[i] == LAT-1) begin auto_ack[i] = switch_target[i]; cnt[i] = 0; end
                    else cnt[i]++;
                end else cnt[i] = 0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read word and compares it with rdata.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic toggle(int id);
        bus_wr(12'h030, 32'h100 | 32'(id));
    endtask

    task automatic settle();
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic check_reset(string tag);
        chk({tag, " R1 target"}, 32'(switch_target), 32'h0);
        chk({tag, " R1 clamp"}, 32'(clamp), 32'h7F);
        chk({tag, " R1 errors"}, {30'b0, err_range, err_busy}, 32'h0);
        bus_rd(12'h038, 32'h0, {tag, " R1 status"});
    endtask

    initial begin
        do_reset();
        check_reset("reset");

        // R2 / R3: power on partition 0
        toggle(0);
        chk("R2 target after toggle", 32'(switch_target), 32'h01);
        settle();
        bus_rd(12'h038, 32'h01, "R3 status after on");

        // R4: start flag clear
        bus_wr(12'h030, 32'h002);
        chk("R4 target unchanged", 32'(switch_target), 32'h01);
        chk("R4 no error", {30'b0, err_range, err_busy}, 32'h0);
        settle();
        bus_rd(12'h038, 32'h01, "R4 status unchanged");

        // R8: out-of-range ids
        toggle(7);
        chk("R8 err_range", 32'(err_range), 32'h1);
        chk("R8 target unchanged", 32'(switch_target), 32'h01);
        toggle(200);
        chk("R8 target unchanged high id", 32'(switch_target), 32'h01);
        chk("R8 clamps unchanged", 32'(clamp), 32'h7F);

        // Power on 3, 4 and 1
        toggle(3); settle();
        toggle(4); settle();
        toggle(1); settle();
        bus_rd(12'h038, 32'h1B, "R3 status four on");

        // R6: release
        bus_wr(12'h034, 32'h01);
        chk("R6 release partition 0", 32'(clamp), 32'h7E);
        bus_wr(12'h034, 32'h04);
        chk("R6 off partition stays clamped", 32'(clamp), 32'h7E);

        // R7: crossed release bits
        bus_wr(12'h034, 32'h10);
        chk("R7 bit 4 releases partition 3", 32'(clamp), 32'h76);
        bus_wr(12'h034, 32'h08);
        chk("R7 bit 3 releases partition 4", 32'(clamp), 32'h66);

        // R9: graphics release word
        bus_wr(12'h2D4, 32'h5);
        chk("R9 nonzero ignored", 32'(clamp), 32'h66);
        bus_wr(12'h2D4, 32'h0);
        chk("R9 zero releases partition 1", 32'(clamp), 32'h64);

        // R12: unmapped reads
        bus_rd(12'h030, 32'h0, "R12 toggle offset reads zero");
        bus_rd(12'h100, 32'h0, "R12 unmapped reads zero");

        // R5: manual switch control
        @(negedge clk); man_ack = auto_ack; sw_manual = 1'b1;
        toggle(5);
        chk("R5 target raised", 32'(switch_target), 32'h3B);
        bus_rd(12'h038, 32'h1B, "R5 status waits for ack");
        @(negedge clk); man_ack[5] = 1'b1;
        @(negedge clk);
        bus_rd(12'h038, 32'h3B, "R5 status after ack");

        // R10: toggle coinciding with completing ack
        toggle(2);
        chk("R10 no busy error yet", 32'(err_busy), 32'h0);
        @(negedge clk); man_ack[2] = 1'b1; wr_en = 1'b1; addr = 12'h030; wdata = 32'h106;
        @(negedge clk); wr_en = 1'b0;
        chk("R10 coincident toggle dropped", 32'(switch_target), 32'h3F);
        chk("R10 err_busy set", 32'(err_busy), 32'h1);
        bus_rd(12'h038, 32'h3F, "R10 completing transition kept");
        toggle(6);
        chk("R10 later toggle accepted", 32'(switch_target), 32'h7F);
        @(negedge clk); man_ack[6] = 1'b1;
        @(negedge clk);
        bus_rd(12'h038, 32'h7F, "R10 status after accept");

        // R11: power off reasserts clamp
        toggle(0);
        chk("R11 clamp on at off", 32'(clamp), 32'h65);
        chk("R11 target low", 32'(switch_target), 32'h7E);
        bus_rd(12'h038, 32'h7F, "R11 status before ack");
        @(negedge clk); man_ack[0] = 1'b0;
        @(negedge clk);
        bus_rd(12'h038, 32'h7E, "R11 status after ack");
        chk("R11 clamp held", 32'(clamp), 32'h65);

        // R1 again, then R10 plain busy case
        @(negedge clk); man_ack = '0;
        do_reset();
        check_reset("second reset");
        toggle(2);
        toggle(3);
        chk("R10 busy toggle dropped", 32'(switch_target), 32'h04);
        chk("R10 busy flag", 32'(err_busy), 32'h1);
        chk("R10 range flag untouched", 32'(err_range), 32'h0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule